// File: doc/BRIEF.md
# Signed Integer Arithmetic Unit with Iterative Divider

This block computes one of four arithmetic operations (add, subtract, multiply, divide) on two `DATA_W`-bit two's-complement operands. The default width is 32 bits. A caller offers a request on a valid/ready input channel: the request carries the opcode and both operands. The unit answers with a one-cycle completion strobe. With that strobe come a result word, a remainder word and an error flag. All three hold their value until the next answer.

Add, subtract and multiply are combinational. They are registered once, so their answer arrives one clock edge after acceptance. Division runs a restoring shift-subtract loop on the operand magnitudes, one quotient bit per cycle. The quotient sign is corrected at the end, so the quotient is truncated toward zero. The remainder word carries the magnitude of the remainder.

Signed overflow, division by zero and the single overflowing division are all reported on the error flag.

Back-pressure rules: `req_ready` is high only while the unit is idle. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. A request offered while `req_ready` is low is not taken and has no effect. The answer strobe cannot be stalled. The caller must sample the outputs at the strobe or at any later time before the next acceptance.

Top module: `sau_top`

## Requirements
- R1: Opcode 2'b00 adds and 2'b01 subtracts. The result is the wrapped DATA_W-bit value. The error flag is set exactly when the true signed result lies outside the DATA_W-bit range, so -2147483647 + (-1) and -2147483647 - 1 give -2147483648 without error, while 5 - (-2147483648) is an error.
- R2: Opcode 2'b10 multiplies. The error flag is set exactly when the full signed product does not fit in DATA_W bits; otherwise the result is the exact product with the correct sign.
- R3: Opcode 2'b11 divides. The quotient is truncated toward zero (for example -5 / 3 = -1 and 7 / 10 = 0).
- R4: After a division, the remainder word holds the non-negative magnitude of the remainder, which is always below the divisor magnitude (for example -2147483648 / 10 leaves 8). After any other operation the remainder word is zero.
- R5: A division by zero, and -2147483648 / -1, set the error flag.
- R6: `res_valid` is a single-cycle pulse. For add, subtract and multiply it rises one clock edge after the accepting edge. For division it rises no more than DATA_W + 2 edges after the accepting edge.
- R7: While a request is in progress, `req_ready` is low and an offered request is ignored. Between pulses, the result word, the remainder word and the error flag do not change.
- R8: While `rst_n` is low (also in the middle of a division), the outputs are zero and `req_ready` is high; the next request after reset completes normally.
- R9: Whenever the error flag is set, the result word and the remainder word are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Unit idle, request can be taken |
| req_op | input | 2 | 00 add, 01 subtract, 10 multiply, 11 divide |
| op_a | input | DATA_W | First operand / dividend, signed |
| op_b | input | DATA_W | Second operand / divisor, signed |
| res_valid | output | 1 | One-cycle completion strobe |
| res_word | output | DATA_W | Sum, difference, product or quotient |
| rem_word | output | DATA_W | Remainder magnitude after division, else zero |
| res_err | output | 1 | Overflow or division by zero |

## Verification
Several properties are checked on every clock cycle:
- the completion strobe lasts a single cycle;
- the outputs stay frozen between strobes;
- an error answer carries zero words;
- a non-divide answer carries a zero remainder;
- an error-free sum of like-signed operands keeps their sign;
- an error-free product of non-zero operands has the XOR sign;
- every division remainder is below the divisor magnitude;
- a zero divisor leads to an error completion two edges later.

Only the bench's scenarios can show the exact numeric values. These cover the overflow boundaries, truncation for every sign combination, the remainder values, the latencies, the refusal of a request during a division, and a reset in the middle of a division.

// File: rtl/sau_pkg.sv
package sau_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_MUL = 2'b10,
    OP_DIV = 2'b11
  } sau_op_e;

  typedef enum logic [1:0] {
    T_IDLE  = 2'd0,
    T_ARITH = 2'd1,
    T_DIV   = 2'd2
  } sau_top_st_e;

  typedef enum logic [1:0] {
    D_IDLE = 2'd0,
    D_RUN  = 2'd1,
    D_FIN  = 2'd2
  } sau_div_st_e;
endpackage

// File: rtl/sau_addsub.sv
module sau_addsub #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              sub,
  output logic [DATA_W-1:0] sum,
  output logic              ovf
);
  logic [DATA_W-1:0] b_eff;

  always_comb begin
    b_eff = sub ? ~b : b;
    sum   = a + b_eff + {{(DATA_W-1){1'b0}}, sub};
    // overflow: both addends share a sign that the sum does not
    ovf   = (a[DATA_W-1] == b_eff[DATA_W-1]) && (sum[DATA_W-1] != a[DATA_W-1]);
  end
endmodule

// File: rtl/sau_mul.sv
module sau_mul #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] prod,
  output logic              ovf
);
  localparam int PW = 2 * DATA_W;
  logic [PW-1:0] full;
  logic [DATA_W:0] upper;

  always_comb begin
    full  = {{DATA_W{a[DATA_W-1]}}, a} * {{DATA_W{b[DATA_W-1]}}, b};
    prod  = full[DATA_W-1:0];
    upper = full[PW-1:DATA_W-1];
    ovf   = (|upper) && !(&upper);
  end
endmodule

// File: rtl/sau_divider.sv
module sau_divider #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] dvd,
  input  logic [DATA_W-1:0] dvs,
  output logic              done,
  output logic [DATA_W-1:0] q_out,
  output logic [DATA_W-1:0] r_out,
  output logic              err_out
);
  import sau_pkg::*;
  localparam int CW = $clog2(DATA_W + 1);
  localparam logic [DATA_W-1:0] MIN_V = {1'b1, {(DATA_W-1){1'b0}}};

  sau_div_st_e st;
  logic [CW-1:0]     cnt;
  logic [DATA_W-1:0] quo_q, rem_q, dvs_q;
  logic              sign_q, err_q;
  logic [DATA_W:0]   shifted, diff;
  logic [DATA_W-1:0] mag_a, mag_b;
  logic              bad;

  always_comb begin
    mag_a   = dvd[DATA_W-1] ? (~dvd + 1'b1) : dvd;
    mag_b   = dvs[DATA_W-1] ? (~dvs + 1'b1) : dvs;
    bad     = (dvs == '0) || ((dvd == MIN_V) && (&dvs));
    shifted = {rem_q, quo_q[DATA_W-1]};
    diff    = shifted - {1'b0, dvs_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= D_IDLE;
      cnt     <= '0;
      quo_q   <= '0;
      rem_q   <= '0;
      dvs_q   <= '0;
      sign_q  <= 1'b0;
      err_q   <= 1'b0;
      done    <= 1'b0;
      q_out   <= '0;
      r_out   <= '0;
      err_out <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        D_IDLE: if (start) begin
          sign_q <= dvd[DATA_W-1] ^ dvs[DATA_W-1];
          err_q  <= bad;
          quo_q  <= mag_a;
          rem_q  <= '0;
          dvs_q  <= mag_b;
          cnt    <= CW'(DATA_W);
          st     <= bad ? D_FIN : D_RUN;
        end
        D_RUN: begin
          if (!diff[DATA_W]) begin
            rem_q <= diff[DATA_W-1:0];
            quo_q <= {quo_q[DATA_W-2:0], 1'b1};
          end else begin
            rem_q <= shifted[DATA_W-1:0];
            quo_q <= {quo_q[DATA_W-2:0], 1'b0};
          end
          cnt <= cnt - 1'b1;
          if (cnt == CW'(1)) st <= D_FIN;
        end
        D_FIN: begin
          done    <= 1'b1;
          err_out <= err_q;
          q_out   <= err_q ? '0 : (sign_q ? (~quo_q + 1'b1) : quo_q);
          r_out   <= err_q ? '0 : rem_q;
          st      <= D_IDLE;
        end
        default: st <= D_IDLE;
      endcase
    end
  end

  // R5: a zero divisor completes with an error two edges after the start
  p_zero_div_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (start && st == D_IDLE && dvs == '0) |=> ##1 (done && err_out));

  // R4: the remainder magnitude stays below the divisor magnitude
  p_rem_below_dvs_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err_out) |-> (r_out < dvs_q));

  // R3: a non-zero quotient carries the XOR of the operand signs
  p_quo_sign_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err_out && q_out != '0) |-> (q_out[DATA_W-1] == sign_q));
endmodule

// File: rtl/sau_top.sv
module sau_top #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_word,
  output logic [DATA_W-1:0] rem_word,
  output logic              res_err
);
  import sau_pkg::*;

  sau_top_st_e       st;
  sau_op_e           op_q;
  logic [DATA_W-1:0] a_q, b_q;
  logic              accept, div_start;
  logic [DATA_W-1:0] as_sum, mul_prod, dq, dr;
  logic              as_ovf, mul_ovf, d_done, d_err;

  assign req_ready = (st == T_IDLE);
  assign accept    = req_valid && req_ready;
  assign div_start = accept && (sau_op_e'(req_op) == OP_DIV);

  sau_addsub #(.DATA_W(DATA_W)) u_addsub (
    .a(a_q), .b(b_q), .sub(op_q == OP_SUB), .sum(as_sum), .ovf(as_ovf));

  sau_mul #(.DATA_W(DATA_W)) u_mul (
    .a(a_q), .b(b_q), .prod(mul_prod), .ovf(mul_ovf));

  sau_divider #(.DATA_W(DATA_W)) u_div (
    .clk(clk), .rst_n(rst_n), .start(div_start), .dvd(op_a), .dvs(op_b),
    .done(d_done), .q_out(dq), .r_out(dr), .err_out(d_err));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= T_IDLE;
      op_q      <= OP_ADD;
      a_q       <= '0;
      b_q       <= '0;
      res_valid <= 1'b0;
      res_word  <= '0;
      rem_word  <= '0;
      res_err   <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      case (st)
        T_IDLE: if (accept) begin
          op_q <= sau_op_e'(req_op);
          a_q  <= op_a;
          b_q  <= op_b;
          st   <= (sau_op_e'(req_op) == OP_DIV) ? T_DIV : T_ARITH;
        end
        T_ARITH: begin
          res_valid <= 1'b1;
          rem_word  <= '0;
          if (op_q == OP_MUL) begin
            res_err  <= mul_ovf;
            res_word <= mul_ovf ? '0 : mul_prod;
          end else begin
            res_err  <= as_ovf;
            res_word <= as_ovf ? '0 : as_sum;
          end
          st <= T_IDLE;
        end
        T_DIV: if (d_done) begin
          res_valid <= 1'b1;
          res_word  <= dq;
          rem_word  <= dr;
          res_err   <= d_err;
          st        <= T_IDLE;
        end
        default: st <= T_IDLE;
      endcase
    end
  end

  // R6: completion strobe lasts one cycle
  p_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  // R7: outputs frozen between strobes
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> ($stable(res_word) && $stable(rem_word) && $stable(res_err)));

  // R9: an error answer carries zero words
  p_err_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_err) |-> (res_word == '0 && rem_word == '0));

  // R4: remainder is zero after a non-divide operation
  p_rem_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && op_q != OP_DIV) |-> (rem_word == '0));

  // R1: an error-free sum of like-signed operands keeps their sign
  p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_err && op_q == OP_ADD && a_q[DATA_W-1] == b_q[DATA_W-1])
      |-> (res_word[DATA_W-1] == a_q[DATA_W-1]));

  // R2: an error-free product of non-zero operands has the XOR sign
  p_mul_sign_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_err && op_q == OP_MUL && a_q != '0 && b_q != '0)
      |-> (res_word[DATA_W-1] == (a_q[DATA_W-1] ^ b_q[DATA_W-1])));
endmodule

// File: tb/sau_top_bench.sv
module sau_top_bench;
  localparam int W = 32;
  localparam int MINV = 32'h8000_0000;

  typedef struct packed {
    logic [1:0] op;
    int         a;
    int         b;
    int         q;
    int         r;
    logic       e;
  } vec_t;

  localparam int NV = 35;
  localparam vec_t TBL [0:NV-1] = '{
    '{2'b00, 7, 3, 10, 0, 1'b0},
    '{2'b00, 2147483647, -1, 2147483646, 0, 1'b0},
    '{2'b00, 2147483647, 1, 0, 0, 1'b1},
    '{2'b00, -2147483645, -100, 0, 0, 1'b1},
    '{2'b00, -2147483647, -1, MINV, 0, 1'b0},
    '{2'b00, -7, 1, -6, 0, 1'b0},
    '{2'b01, 7, 1, 6, 0, 1'b0},
    '{2'b01, -7, -1, -6, 0, 1'b0},
    '{2'b01, -2147483645, 1000, 0, 0, 1'b1},
    '{2'b01, 2147483645, -1000, 0, 0, 1'b1},
    '{2'b01, 5, MINV, 0, 0, 1'b1},
    '{2'b01, -2147483647, 1, MINV, 0, 1'b0},
    '{2'b01, 1000, -2147483645, 0, 0, 1'b1},
    '{2'b10, 7, 3, 21, 0, 1'b0},
    '{2'b10, -3, -2, 6, 0, 1'b0},
    '{2'b10, 3, -2, -6, 0, 1'b0},
    '{2'b10, 268435456, -2, -536870912, 0, 1'b0},
    '{2'b10, 90000, 100000, 0, 0, 1'b1},
    '{2'b10, -90000, 100000, 0, 0, 1'b1},
    '{2'b10, 90000, -100000, 0, 0, 1'b1},
    '{2'b10, -90000, -100000, 0, 0, 1'b1},
    '{2'b11, -5, 3, -1, 2, 1'b0},
    '{2'b11, 7, 3, 2, 1, 1'b0},
    '{2'b11, 153156, 3543, 43, 807, 1'b0},
    '{2'b11, -153156, 3543, -43, 807, 1'b0},
    '{2'b11, 153156, -3543, -43, 807, 1'b0},
    '{2'b11, -153156, -3543, 43, 807, 1'b0},
    '{2'b11, MINV, 10, -214748364, 8, 1'b0},
    '{2'b11, 7, 10, 0, 7, 1'b0},
    '{2'b11, 10, 10, 1, 0, 1'b0},
    '{2'b11, 1234, 3, 411, 1, 1'b0},
    '{2'b11, 5134123, 358015, 14, 121913, 1'b0},
    '{2'b11, 0, 10, 0, 0, 1'b0},
    '{2'b11, MINV, -1, 0, 0, 1'b1},
    '{2'b11, 5, 0, 0, 0, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = 2'b00;
  logic [W-1:0] op_a = '0, op_b = '0;
  logic        res_valid;
  logic [W-1:0] res_word, rem_word;
  logic        res_err;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  sau_top #(.DATA_W(W)) u_sau_top (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .op_a(op_a), .op_b(op_b), .res_valid(res_valid),
    .res_word(res_word), .rem_word(rem_word), .res_err(res_err));

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] op, input int a, input int b,
                        output int q, output int r, output logic e, output int lat);
    int n;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; op_a = a; op_b = b;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    n = 1;
    while (!res_valid && n < 100) begin
      @(negedge clk);
      n++;
    end
    lat = n - 1;
    q = res_word; r = rem_word; e = res_err;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int q, r, lat;
    logic e;
    string tq, te;
    repeat (3) @(negedge clk);
    // R8: reset state
    chk("R8 ready in reset", int'(req_ready), 1);
    chk("R8 valid in reset", int'(res_valid), 0);
    chk("R8 word in reset", res_word, 0);
    chk("R8 err in reset", int'(res_err), 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      run_op(TBL[i].op, TBL[i].a, TBL[i].b, q, r, e, lat);
      case (TBL[i].op)
        2'b00, 2'b01: begin tq = "R1 result"; te = "R1 error"; end
        2'b10:        begin tq = "R2 result"; te = "R2 error"; end
        default:      begin tq = "R3 quotient"; te = "R5 error"; end
      endcase
      if (TBL[i].e) tq = "R9 word on error";
      chk(tq, q, TBL[i].q);
      chk(TBL[i].e ? "R9 rem on error" : "R4 remainder", r, TBL[i].r);
      chk(te, int'(e), int'(TBL[i].e));
      if (TBL[i].op != 2'b11) chk("R6 arith latency", lat, 1);
      else chk("R6 divide latency bound", int'(lat <= W + 2), 1);
      @(negedge clk);
      chk("R6 pulse width", int'(res_valid), 0);
    end

    // R7: request during a division is ignored
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'b11; op_a = 100; op_b = 7;
    @(negedge clk);
    req_op = 2'b00; op_a = 1; op_b = 1;
    for (int k = 0; k < 10; k++) begin
      if (k == 5) chk("R7 ready low while busy", int'(req_ready), 0);
      @(negedge clk);
    end
    req_valid = 1'b0;
    while (!res_valid) @(negedge clk);
    chk("R7 divide result kept", res_word, 14);
    chk("R7 divide remainder kept", rem_word, 2);
    begin
      int extra = 0;
      for (int k = 0; k < 10; k++) begin
        @(negedge clk);
        if (res_valid) extra++;
      end
      chk("R7 no extra answer", extra, 0);
      chk("R7 word held", res_word, 14);
    end

    // R8: reset in the middle of a division
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'b11; op_a = 99; op_b = 4;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R8 word cleared mid-divide", res_word, 0);
    chk("R8 ready after reset", int'(req_ready), 1);
    rst_n = 1'b1;
    repeat (40) @(negedge clk);
    chk("R8 no stale answer", int'(res_valid), 0);
    run_op(2'b00, 2, 3, q, r, e, lat);
    chk("R8 add after reset", q, 5);
    run_op(2'b11, 99, 4, q, r, e, lat);
    chk("R3 divide after reset", q, 24);
    chk("R4 remainder after reset", r, 3);
    run_op(2'b10, 6, 7, q, r, e, lat);
    chk("R4 remainder cleared after multiply", r, 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule